// File: doc/BRIEF.md
# Eye Monitor Bit-Error Counter

This block measures the bit error rate between two sampled copies of one serial stream. The first copy comes from the main clock-and-data recovery path. The second comes from an eye-measurement sampler that is set to an offset sampling point. Both arrive as parallel words, qualified by one valid strobe. While the block is running, each mismatching bit position adds one to a 64-bit error counter. Every 256 received bits add one to a 64-bit total-bits counter. An 8-bit residual accumulator carries the part of a 256-bit group that is not yet complete.

Software controls the block through a 32-bit register port. The read data comes out one cycle after the read strobe. A mode register holds the monitor enable, the checker enable and the counter enable, together with a self-clearing counter reset. A control register holds the eye-shape and vertical-sign fields. All of its other bits are stored and returned unchanged, so that software can update them by read-modify-write. The block drives two outputs from the control register for the offset sampler: whether the vertical axis is measured, and the sign of the vertical offset. Each counter is read as two words, low word first. Reading the low word captures the high word at the same moment, so the two words form one consistent 64-bit value.

Top module: `eyemon_berc`

## Requirements
- R1: On each cycle with `rx_valid` high while both enables are set, the error counter grows by the number of bit positions where `ref_data` and `eye_data` differ.
- R2: The total-bits counter advances by one for every 256 bits counted. An 8-bit residual carries the remainder from one cycle to the next, so with 32-bit words the counter advances on every eighth counted word.
- R3: Neither counter changes unless `rx_valid` is high and both the checker enable (mode bit 1) and the counter enable (mode bit 2) are set.
- R4: Both counters and the residual clear to zero on a mode-register write with bit 3 set. They also clear on a mode-register write that sets both enables when they were not both set before. Bit 3 reads back as 0.
- R5: Mode is at offset 0x2 and control at offset 0x3. The bit counter is at 0x5 (low) and 0x6 (high); the error counter is at 0x7 (low) and 0x8 (high). Read data appears on the cycle after `reg_rd`. Unmapped offsets read 0.
- R6: A read of a counter's low word captures that counter's high word in a shadow register. A later read of the high word returns the shadow value.
- R7: Control bit 13 set selects one-dimensional eye mode and drives `vert_meas_en` low; clear, it selects the two-axis mode. Control bit 2 drives `vert_pos`: 1 means positive, 0 means negative.
- R8: A mode-register write with bit 0 (monitor enable) set forces control bit 2 to 1.
- R9: All control bits other than bit 2 and bit 13 are stored as written and read back unchanged. No other event alters them.
- R10: After reset, the counters, the mode register and the read data are 0, and the control register holds 0x0000_0004.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Data words valid this cycle |
| ref_data | input | DATA_W | Word from the main recovery path |
| eye_data | input | DATA_W | Word from the offset eye sampler |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data, valid the cycle after `reg_rd` |
| vert_meas_en | output | 1 | Vertical axis measured (two-axis mode) |
| vert_pos | output | 1 | Vertical offset sign, 1 = positive |

## Verification
The assertions check the following on every cycle:
- An idle cycle leaves both counters unchanged.
- One counted word adds at most one word's width of errors and at most one step of the bit counter.
- A clear leaves both counters at zero.
- The monitor-enable write forces the polarity bit to 1, and the stored control bits hold between writes.
- The low-word read returns the live count, and the shadow changes only on a low-word read.

Only the bench's scenarios can show the following:
- The exact error sums for chosen mismatch patterns.
- When the 256-bit carry occurs, and that a counter reset in mid-group discards the residual.
- That re-enabling the counters restarts them from zero.
- That the vertical outputs follow the control fields.

// File: rtl/eyemon_pkg.sv
// Package: register offsets, field positions and the mode type shared by
// the eye monitor bit-error counter. Assumes a register word of at least
// 14 bits so the control fields fit.
package eyemon_pkg;

    // register offsets (software decodes these)
    localparam int OFS_MODE   = 2;
    localparam int OFS_CTRL   = 3;
    localparam int OFS_BIT_LO = 5;
    localparam int OFS_BIT_HI = 6;
    localparam int OFS_ERR_LO = 7;
    localparam int OFS_ERR_HI = 8;

    // mode register bits
    localparam int MB_MON = 0;
    localparam int MB_CHK = 1;
    localparam int MB_CNT = 2;
    localparam int MB_CLR = 3;

    // control register bits
    localparam int CB_POL   = 2;
    localparam int CB_ONE_D = 13;

    // control register reset value: positive polarity, two-axis mode
    localparam int CTRL_RST = 4;

    typedef struct packed {
        logic cnt_en;
        logic chk_en;
        logic mon_en;
    } mode_t;

endpackage

// File: rtl/eyemon_regs.sv
// Module: mode and control registers.
// Holds the three enables and the full control word (reserved bits stored
// verbatim). Produces a one-cycle clear pulse on a counter-reset write or
// on a write that turns counting on. Assumes one access per cycle.
module eyemon_regs
    import eyemon_pkg::*;
#(
    parameter int REG_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output mode_t             mode,
    output logic [REG_W-1:0]  ctrl,
    output logic              clr
);

    logic wr_mode;
    logic wr_ctrl;
    logic new_run;
    logic old_run;

    // decode writes and detect the counting-on transition
    always_comb begin
        wr_mode = reg_wr && (reg_addr == ADDR_W'(OFS_MODE));
        wr_ctrl = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL));
        new_run = reg_wdata[MB_CHK] && reg_wdata[MB_CNT];
        old_run = mode.chk_en && mode.cnt_en;
        clr     = wr_mode && (reg_wdata[MB_CLR] || (new_run && !old_run));
    end

    // mode register: stores the three enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= '0;
        end else if (wr_mode) begin
            mode <= mode_t'{cnt_en: reg_wdata[MB_CNT],
                            chk_en: reg_wdata[MB_CHK],
                            mon_en: reg_wdata[MB_MON]};
        end
    end

    // control register: full word write, polarity forced by monitor enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= REG_W'(CTRL_RST);
        end else if (wr_ctrl) begin
            ctrl <= reg_wdata;
        end else if (wr_mode && reg_wdata[MB_MON]) begin
            ctrl[CB_POL] <= 1'b1;
        end
    end

    logic armed;
    // marks the first cycle after reset for the checks below
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R8
    mon_en_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && reg_wr && (reg_addr == ADDR_W'(OFS_MODE)) && reg_wdata[MB_MON]
        |=> ctrl[CB_POL]);

    // R9
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !(reg_wr && (reg_addr == ADDR_W'(OFS_CTRL)))
        |=> $stable(ctrl[REG_W-1:CB_POL+1]) && $stable(ctrl[CB_POL-1:0]));

endmodule

// File: rtl/eyemon_accum.sv
// Module: bit and error accumulators.
// Counts mismatching bit positions between the two sampled words and
// counts received bits in groups of 2**RES_W through a residual carry.
// Assumes DATA_W <= 2**RES_W so at most one carry occurs per word.
module eyemon_accum #(
    parameter int DATA_W = 32,
    parameter int RES_W  = 8,
    parameter int CNT_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              run,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] ref_data,
    input  logic [DATA_W-1:0] eye_data,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic [CNT_W-1:0]  err_cnt
);

    localparam int NERR_W = $clog2(DATA_W + 1);
    localparam int SUM_W  = RES_W + 2;

    logic [DATA_W-1:0] diff;
    logic [NERR_W-1:0] nerr;
    logic [RES_W-1:0]  resid;
    logic [SUM_W-1:0]  sum;
    logic              go;

    // population count of the mismatch vector and the residual sum
    always_comb begin
        diff = ref_data ^ eye_data;
        nerr = '0;
        for (int i = 0; i < DATA_W; i++) begin
            nerr = nerr + NERR_W'(diff[i]);
        end
        sum = SUM_W'(resid) + SUM_W'(DATA_W);
        go  = run && rx_valid;
    end

    // accumulate counts; clear has priority
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            resid   <= '0;
            bit_cnt <= '0;
            err_cnt <= '0;
        end else if (go) begin
            resid   <= sum[RES_W-1:0];
            bit_cnt <= bit_cnt + CNT_W'(sum[SUM_W-1:RES_W]);
            err_cnt <= err_cnt + CNT_W'(nerr);
        end
    end

    logic armed;
    // marks the first cycle after reset for the checks below
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !(run && rx_valid) && !clr
        |=> $stable(bit_cnt) && $stable(err_cnt));

    // R1
    err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !clr |=> (err_cnt - $past(err_cnt)) <= CNT_W'(DATA_W));

    // R2
    bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !clr |=> (bit_cnt - $past(bit_cnt)) <= CNT_W'(1));

    // R4
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (bit_cnt == '0) && (err_cnt == '0));

endmodule

// File: rtl/eyemon_readback.sv
// Module: registered read path with high-word shadows.
// A low-word read of either counter captures its high word so the later
// high-word read is coherent. Read data is valid the cycle after reg_rd.
module eyemon_readback
    import eyemon_pkg::*;
#(
    parameter int REG_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [2*REG_W-1:0] bit_cnt,
    input  logic [2*REG_W-1:0] err_cnt,
    input  mode_t              mode,
    input  logic [REG_W-1:0]   ctrl,
    output logic [REG_W-1:0]   reg_rdata
);

    logic [REG_W-1:0] bit_sh;
    logic [REG_W-1:0] err_sh;
    logic             rd_bit_lo;
    logic             rd_err_lo;

    // decode low-word reads
    always_comb begin
        rd_bit_lo = reg_rd && (reg_addr == ADDR_W'(OFS_BIT_LO));
        rd_err_lo = reg_rd && (reg_addr == ADDR_W'(OFS_ERR_LO));
    end

    // capture high words on low-word reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_sh <= '0;
            err_sh <= '0;
        end else begin
            if (rd_bit_lo) bit_sh <= bit_cnt[2*REG_W-1:REG_W];
            if (rd_err_lo) err_sh <= err_cnt[2*REG_W-1:REG_W];
        end
    end

    // registered read multiplexer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            case (reg_addr)
                ADDR_W'(OFS_MODE):   reg_rdata <= REG_W'({mode.cnt_en, mode.chk_en, mode.mon_en});
                ADDR_W'(OFS_CTRL):   reg_rdata <= ctrl;
                ADDR_W'(OFS_BIT_LO): reg_rdata <= bit_cnt[REG_W-1:0];
                ADDR_W'(OFS_BIT_HI): reg_rdata <= bit_sh;
                ADDR_W'(OFS_ERR_LO): reg_rdata <= err_cnt[REG_W-1:0];
                ADDR_W'(OFS_ERR_HI): reg_rdata <= err_sh;
                default:             reg_rdata <= '0;
            endcase
        end
    end

    logic armed;
    // marks the first cycle after reset for the checks below
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R5
    lo_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && reg_rd && (reg_addr == ADDR_W'(OFS_ERR_LO))
        |=> reg_rdata == $past(err_cnt[REG_W-1:0]));

    // R6
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !(reg_rd && (reg_addr == ADDR_W'(OFS_BIT_LO)))
        |=> $stable(bit_sh));

endmodule

// File: rtl/eyemon_berc.sv
// Module: eye monitor bit-error counter, top level.
// Compares main-path and eye-path words, accumulates 64-bit bit and error
// counts, and exposes mode/control/counter registers on a simple port.
// Assumes REG_W >= 14 and DATA_W <= 2**RES_W.
module eyemon_berc
    import eyemon_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_W  = 32,
    parameter int ADDR_W = 4,
    parameter int RES_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] ref_data,
    input  logic [DATA_W-1:0] eye_data,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              vert_meas_en,
    output logic              vert_pos
);

    localparam int CNT_W = 2 * REG_W;

    mode_t            mode;
    logic [REG_W-1:0] ctrl;
    logic             clr;
    logic             run;
    logic [CNT_W-1:0] bit_cnt;
    logic [CNT_W-1:0] err_cnt;

    eyemon_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .mode(mode), .ctrl(ctrl), .clr(clr)
    );

    // counting runs only with both checker and counter enabled
    always_comb begin
        run          = mode.chk_en && mode.cnt_en;
        vert_meas_en = !ctrl[CB_ONE_D];
        vert_pos     = ctrl[CB_POL];
    end

    eyemon_accum #(.DATA_W(DATA_W), .RES_W(RES_W), .CNT_W(CNT_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .clr(clr), .run(run), .rx_valid(rx_valid),
        .ref_data(ref_data), .eye_data(eye_data),
        .bit_cnt(bit_cnt), .err_cnt(err_cnt)
    );

    eyemon_readback #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_rdbk (
        .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .bit_cnt(bit_cnt), .err_cnt(err_cnt), .mode(mode), .ctrl(ctrl),
        .reg_rdata(reg_rdata)
    );

    // R7
    vert_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && (reg_addr == ADDR_W'(OFS_CTRL))
        |=> (vert_meas_en == !$past(reg_wdata[CB_ONE_D]))
            && (vert_pos == $past(reg_wdata[CB_POL])));

endmodule

// File: tb/eyemon_berc_tb.sv
module eyemon_berc_tb;

    localparam int DW = 32;
    localparam int RW = 32;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0;
    logic [DW-1:0] ref_data = '0;
    logic [DW-1:0] eye_data = '0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [RW-1:0] reg_wdata = '0;
    logic [RW-1:0] reg_rdata;
    logic          vert_meas_en;
    logic          vert_pos;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    eyemon_berc #(.DATA_W(DW), .REG_W(RW), .ADDR_W(AW), .RES_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .ref_data(ref_data),
        .eye_data(eye_data), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .vert_meas_en(vert_meas_en), .vert_pos(vert_pos)
    );

    // {ref word, eye word, expected mismatching bits}
    localparam logic [69:0] TBL [8] = '{
        {32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'd0},
        {32'h0000_0000, 32'h0000_0001, 6'd1},
        {32'hAAAA_AAAA, 32'h5555_5555, 6'd32},
        {32'h0000_FFFF, 32'h0000_0000, 6'd16},
        {32'h1234_5678, 32'h1234_5678, 6'd0},
        {32'hF0F0_F0F0, 32'hF0F0_F0F1, 6'd1},
        {32'h8000_0000, 32'h0000_0000, 6'd1},
        {32'h0F0F_0F0F, 32'h0000_0000, 6'd16}
    };

    task automatic check(input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [RW-1:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = AW'(addr); reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [RW-1:0] data);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = AW'(addr);
        @(negedge clk);
        reg_rd = 1'b0;
        data = reg_rdata;
    endtask

    task automatic push(input logic [DW-1:0] r, input logic [DW-1:0] e, input logic v);
        @(negedge clk);
        rx_valid = v; ref_data = r; eye_data = e;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic push_tbl(input int i);
        push(TBL[i][69:38], TBL[i][37:6], 1'b1);
    endtask

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [RW-1:0] v;
        int exp_err;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        check("R10 rdata", reg_rdata, 32'h0);
        rd(3, v); check("R10 ctrl", v, 32'h0000_0004);
        rd(2, v); check("R10 mode", v, 32'h0);
        rd(5, v); check("R10 bitlo", v, 32'h0);
        rd(7, v); check("R10 errlo", v, 32'h0);
        check("R7 reset meas", 32'(vert_meas_en), 32'h1);
        check("R7 reset pos", 32'(vert_pos), 32'h1);
        rd(12, v); check("R5 unmapped", v, 32'h0);

        // R3: checker on, counter off -> nothing counted
        wr(2, 32'h2);
        push_tbl(2);
        rd(7, v); check("R3 cnt off err", v, 32'h0);

        // enable both (clears), then valid low -> nothing counted
        wr(2, 32'h6);
        rd(2, v); check("R5 mode read", v, 32'h6);
        push(32'hFFFF_FFFF, 32'h0, 1'b0);
        rd(7, v); check("R3 valid low err", v, 32'h0);
        rd(5, v); check("R3 valid low bit", v, 32'h0);

        // R1/R2: table walk, error total read after each word
        exp_err = 0;
        for (int i = 0; i < 8; i++) begin
            push_tbl(i);
            exp_err += int'(TBL[i][5:0]);
            rd(7, v); check("R1 err walk", v, 32'(exp_err));
            rd(5, v); check("R2 bit walk", v, (i == 7) ? 32'h1 : 32'h0);
        end
        rd(6, v); check("R6 bit hi", v, 32'h0);
        rd(7, v);
        rd(8, v); check("R6 err hi", v, 32'h0);

        // R4: counter reset mid-group drops residual
        for (int i = 0; i < 4; i++) push_tbl(i);
        wr(2, 32'hE);
        rd(7, v); check("R4 clr err", v, 32'h0);
        rd(5, v); check("R4 clr bit", v, 32'h0);
        rd(2, v); check("R4 clr bit reads 0", v, 32'h6);
        for (int i = 0; i < 7; i++) push_tbl(i);
        rd(5, v); check("R4 residual cleared", v, 32'h0);
        push_tbl(7);
        rd(5, v); check("R2 carry after 8", v, 32'h1);
        rd(7, v); check("R1 err after clr", v, 32'd67);

        // R4: disable keeps counts, re-enable restarts from zero
        wr(2, 32'h2);
        rd(7, v); check("R4 hold while off", v, 32'd67);
        wr(2, 32'h6);
        rd(7, v); check("R4 restart err", v, 32'h0);
        rd(5, v); check("R4 restart bit", v, 32'h0);

        // R9/R7: reserved bits stored, fields drive outputs
        wr(3, 32'hDEAD_A5F0);
        rd(3, v); check("R9 ctrl readback", v, 32'hDEAD_A5F0);
        check("R7 one-dim meas", 32'(vert_meas_en), 32'h0);
        check("R7 neg pol", 32'(vert_pos), 32'h0);
        push_tbl(2);
        rd(3, v); check("R9 ctrl after data", v, 32'hDEAD_A5F0);

        // R8: monitor enable forces polarity, rest untouched
        wr(2, 32'h7);
        rd(3, v); check("R8 pol forced", v, 32'hDEAD_A5F4);
        check("R8 vert_pos", 32'(vert_pos), 32'h1);
        rd(7, v); check("R4 no clr when already on", v, 32'd32);

        wr(3, 32'h0);
        check("R7 two-axis meas", 32'(vert_meas_en), 32'h1);
        check("R7 neg pol 2", 32'(vert_pos), 32'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule